// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block turns a single PWM command into the two switch enables of a synchronous buck half-bridge. Dead time is adaptive: each switch is enabled only after a digital flag reports that the opposite gate has actually discharged, rather than after a fixed count. Once the upper switch turns off it stays off for a programmable minimum time. Once the lower switch turns on it stays on for a programmable minimum interval. Partway through that interval a one-cycle strobe tells the overcurrent comparator logic when to sample the switch node.

A mode input picks between two behaviours. In forced continuous mode the lower switch conducts for the whole off period. In diode emulation mode a zero-cross flag turns the lower switch off, and it stays off until the next falling edge of PWM. A tristate request parks both switches off at once.

If a gate-low flag never arrives while the sequencer waits on it, a watchdog parks both switches off and raises a fault flag. The flag holds until reset. All timing values are parameters in clock cycles.

Top module: `hb_gate_seq`

## Requirements
- R1: `hi_en_o` and `lo_en_o` are never high in the same cycle.
- R2: `hi_en_o` rises one cycle after a cycle in which the sequencer is waiting to turn the upper switch on, `pwm_i` is 1, `lo_gate_off_i` is 1 and the minimum off time has elapsed. While `lo_gate_off_i` is 0 the upper switch stays off. A rising `pwm_i` from idle first gives one dead-time cycle with both enables low.
- R3: `lo_en_o` rises only after `pwm_i` has fallen during an upper pulse. It rises one cycle after `hi_gate_off_i` is seen at 1. While that flag is 0 the lower switch stays off. With no preceding upper pulse the lower switch never turns on.
- R4: A falling `pwm_i` while the upper switch is on drops `hi_en_o` at the next clock edge.
- R5: Once `hi_en_o` falls it stays low for at least MIN_OFF_CYC cycles, even if `pwm_i` is already high. If `pwm_i` is high and `lo_gate_off_i` is 1, it rises again after exactly MIN_OFF_CYC+1 low cycles.
- R6: `oc_sample_o` is high for exactly one cycle, OC_DLY_CYC cycles after `lo_en_o` first reads high. `lo_en_o` stays high at least through that cycle, even if `pwm_i` rises or the zero-cross flag asserts earlier.
- R7: With `ccm_force_i` = 0, a high `zc_i` after the minimum lower interval drops `lo_en_o` at the next edge. The lower switch then stays off until the next fall of `pwm_i`, even if `zc_i` drops or `ccm_force_i` rises in between.
- R8: With `ccm_force_i` = 1, `zc_i` has no effect and `lo_en_o` stays high until `pwm_i` rises.
- R9: `hiz_i` = 1 forces both enables low at the next edge and keeps them low whatever `pwm_i` does. After release with `pwm_i` high, the upper switch returns after its minimum off time. After release with `pwm_i` low, the lower switch stays off.
- R10: If the sequencer waits on a gate-low flag for FB_TIMEOUT_CYC consecutive cycles, `fb_fault_o` rises at the next edge. Both enables are then held low and the fault holds until reset.
- R11: During and right after reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command, high requests upper conduction |
| ccm_force_i | input | 1 | 1 = forced continuous mode, 0 = diode emulation |
| lo_gate_off_i | input | 1 | Lower gate discharged flag |
| hi_gate_off_i | input | 1 | Upper gate-to-switch-node discharged flag |
| zc_i | input | 1 | Inductor current zero-cross flag |
| hiz_i | input | 1 | Request to hold both switches off |
| hi_en_o | output | 1 | Upper switch enable |
| lo_en_o | output | 1 | Lower switch enable |
| oc_sample_o | output | 1 | One-cycle overcurrent sample strobe |
| fb_fault_o | output | 1 | Sticky gate feedback timeout fault |

## Verification
The hardest coincidence is a request to hand over from the lower switch to the upper one that lands inside the lower switch's guaranteed interval. The bench raises `pwm_i` one cycle after the lower switch turns on. It then checks that the lower enable holds through the sample strobe and drops the cycle after it. It also checks that the upper enable waits for the full minimum off time. A second case raises `pwm_i` and `zc_i` in the same cycle after that interval. The rising PWM must win: both enables go low for one cycle, then the upper enable rises.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  // Sequencer phases; dead-time phases wait on gate feedback.
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_HI_DT = 3'd1,
    ST_HI_ON = 3'd2,
    ST_LO_DT = 3'd3,
    ST_LO_ON = 3'd4,
    ST_FAULT = 3'd5
  } hb_state_e;

endpackage

// File: rtl/hb_sat_counter.sv
module hb_sat_counter #(
  parameter int MAX_VAL    = 40,
  parameter int CNT_W      = $clog2(MAX_VAL + 1),
  parameter bit RST_AT_MAX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(MAX_VAL);
  localparam logic [CNT_W-1:0] RST_VAL = RST_AT_MAX ? TOP_VAL : '0;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i && (cnt_q != TOP_VAL)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/hb_fb_watchdog.sv
module hb_fb_watchdog
  import hb_gate_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  hb_state_e state_i,
  input  logic      lo_gate_off_i,
  input  logic      hi_gate_off_i,
  output logic      timeout_o
);

  localparam int WD_MAX = TIMEOUT_CYC - 1;
  localparam int WD_W   = $clog2(WD_MAX + 1);

  logic            waiting;
  logic [WD_W-1:0] wait_cnt;

  // Waiting means a dead-time phase whose awaited flag is still low.
  always_comb begin
    waiting = 1'b0;
    if ((state_i == ST_HI_DT) && !lo_gate_off_i) waiting = 1'b1;
    if ((state_i == ST_LO_DT) && !hi_gate_off_i) waiting = 1'b1;
  end

  hb_sat_counter #(
    .MAX_VAL    (WD_MAX),
    .CNT_W      (WD_W),
    .RST_AT_MAX (1'b0)
  ) u_wait_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (!waiting),
    .inc_i (waiting),
    .cnt_o (wait_cnt)
  );

  assign timeout_o = waiting && (wait_cnt == WD_W'(WD_MAX));

endmodule

// File: rtl/hb_seq_fsm.sv
module hb_seq_fsm
  import hb_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwm_i,
  input  logic      ccm_force_i,
  input  logic      lo_gate_off_i,
  input  logic      hi_gate_off_i,
  input  logic      zc_i,
  input  logic      hiz_i,
  input  logic      min_off_ok_i,
  input  logic      lo_min_done_i,
  input  logic      fb_timeout_i,
  output hb_state_e state_o,
  output logic      hi_fall_o
);

  hb_state_e state_q;
  hb_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_FAULT) begin
      state_d = ST_FAULT;
    end else if (hiz_i) begin
      state_d = ST_OFF;
    end else if (fb_timeout_i) begin
      state_d = ST_FAULT;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          // Lower never starts from idle: a pre-charged output is kept.
          if (pwm_i) state_d = ST_HI_DT;
        end
        ST_HI_DT: begin
          if (!pwm_i) begin
            state_d = ST_OFF;
          end else if (lo_gate_off_i && min_off_ok_i) begin
            state_d = ST_HI_ON;
          end
        end
        ST_HI_ON: begin
          if (!pwm_i) state_d = ST_LO_DT;
        end
        ST_LO_DT: begin
          if (hi_gate_off_i) state_d = ST_LO_ON;
        end
        ST_LO_ON: begin
          if (lo_min_done_i) begin
            if (pwm_i) begin
              state_d = ST_HI_DT;
            end else if (!ccm_force_i && zc_i) begin
              state_d = ST_OFF;
            end
          end
        end
        default: state_d = ST_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o   = state_q;
  assign hi_fall_o = (state_q == ST_HI_ON) && (state_d != ST_HI_ON);

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_gate_pkg::*;
#(
  parameter int MIN_OFF_CYC    = 40,
  parameter int OC_DLY_CYC     = 27,
  parameter int FB_TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic ccm_force_i,
  input  logic lo_gate_off_i,
  input  logic hi_gate_off_i,
  input  logic zc_i,
  input  logic hiz_i,
  output logic hi_en_o,
  output logic lo_en_o,
  output logic oc_sample_o,
  output logic fb_fault_o
);

  localparam int OFF_W  = $clog2(MIN_OFF_CYC + 1);
  localparam int LO_MAX = OC_DLY_CYC + 1;
  localparam int LO_W   = $clog2(LO_MAX + 1);

  hb_state_e        state;
  logic             hi_fall;
  logic             min_off_ok;
  logic             lo_min_done;
  logic             fb_timeout;
  logic             in_lo_on;
  logic [OFF_W-1:0] off_cnt;
  logic [LO_W-1:0]  lo_cnt;

  assign in_lo_on = (state == ST_LO_ON);

  hb_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_i         (pwm_i),
    .ccm_force_i   (ccm_force_i),
    .lo_gate_off_i (lo_gate_off_i),
    .hi_gate_off_i (hi_gate_off_i),
    .zc_i          (zc_i),
    .hiz_i         (hiz_i),
    .min_off_ok_i  (min_off_ok),
    .lo_min_done_i (lo_min_done),
    .fb_timeout_i  (fb_timeout),
    .state_o       (state),
    .hi_fall_o     (hi_fall)
  );

  // Upper off-time: restarts at every upper turn-off, saturates when met.
  hb_sat_counter #(
    .MAX_VAL    (MIN_OFF_CYC),
    .CNT_W      (OFF_W),
    .RST_AT_MAX (1'b1)
  ) u_off_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (hi_fall),
    .inc_i (1'b1),
    .cnt_o (off_cnt)
  );

  // Lower interval: runs only while the lower switch conducts.
  hb_sat_counter #(
    .MAX_VAL    (LO_MAX),
    .CNT_W      (LO_W),
    .RST_AT_MAX (1'b0)
  ) u_lo_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (!in_lo_on),
    .inc_i (in_lo_on),
    .cnt_o (lo_cnt)
  );

  hb_fb_watchdog #(
    .TIMEOUT_CYC (FB_TIMEOUT_CYC)
  ) u_wdog (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_i       (state),
    .lo_gate_off_i (lo_gate_off_i),
    .hi_gate_off_i (hi_gate_off_i),
    .timeout_o     (fb_timeout)
  );

  assign min_off_ok  = (off_cnt == OFF_W'(MIN_OFF_CYC));
  assign lo_min_done = (lo_cnt >= LO_W'(OC_DLY_CYC));

  assign hi_en_o     = (state == ST_HI_ON);
  assign lo_en_o     = in_lo_on;
  assign oc_sample_o = in_lo_on && (lo_cnt == LO_W'(OC_DLY_CYC));
  assign fb_fault_o  = (state == ST_FAULT);

endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
  parameter int MIN_OFF_CYC = 40
) (
  input logic clk,
  input logic rst_n,
  input logic pwm_i,
  input logic lo_gate_off_i,
  input logic hi_gate_off_i,
  input logic hiz_i,
  input logic hi_en_o,
  input logic lo_en_o,
  input logic oc_sample_o,
  input logic fb_fault_o
);

  localparam int GW = $clog2(MIN_OFF_CYC + 2);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GW'(MIN_OFF_CYC);
    end else if (hi_en_o) begin
      gap_q <= '0;
    end else if (gap_q != GW'(MIN_OFF_CYC)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R1
  excl_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_en_o && lo_en_o));

  // R2
  hi_turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_en_o) |-> $past(pwm_i && lo_gate_off_i));

  // R3
  lo_turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_en_o) |-> $past(hi_gate_off_i));

  // R5
  min_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_en_o) |-> (gap_q == GW'(MIN_OFF_CYC)));

  // R6
  strobe_in_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_sample_o |-> lo_en_o);

  // R9
  hiz_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_i |=> (!hi_en_o && !lo_en_o));

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_fault_o |=> (fb_fault_o && !hi_en_o && !lo_en_o));

endmodule

bind hb_gate_seq hb_gate_seq_chk #(.MIN_OFF_CYC(MIN_OFF_CYC)) u_hb_gate_seq_chk (.*);

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;

  localparam int MIN_OFF = 40;
  localparam int OC      = 27;
  localparam int TO      = 64;

  logic clk, rst_n;
  logic pwm, ccm, lo_off, hi_off, zc, hiz;
  logic hi_en, lo_en, oc_s, fault;
  logic fb_auto, overlap_seen, prev_hi;
  int   n_chk, n_bad, low_run, last_gap;

  hb_gate_seq #(
    .MIN_OFF_CYC    (MIN_OFF),
    .OC_DLY_CYC     (OC),
    .FB_TIMEOUT_CYC (TO)
  ) i_hb_gate_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_i         (pwm),
    .ccm_force_i   (ccm),
    .lo_gate_off_i (lo_off),
    .hi_gate_off_i (hi_off),
    .zc_i          (zc),
    .hiz_i         (hiz),
    .hi_en_o       (hi_en),
    .lo_en_o       (lo_en),
    .oc_sample_o   (oc_s),
    .fb_fault_o    (fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Gate model: each discharged flag follows its enable one cycle late.
  always @(negedge clk) begin
    if (fb_auto) begin
      lo_off = !lo_en;
      hi_off = !hi_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n && hi_en && lo_en) overlap_seen = 1'b1;
    if (hi_en && !prev_hi) last_gap = low_run;
    if (hi_en) low_run = 0;
    else       low_run = low_run + 1;
    prev_hi = hi_en;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic go_idle();
    hiz = 0; fb_auto = 1; ccm = 0; zc = 1; pwm = 0;
    step(OC + 6);
    zc = 0;
    step(MIN_OFF + 4);
  endtask

  task automatic t_reset();
    rst_n = 0; pwm = 0; ccm = 0; zc = 0; hiz = 0; fb_auto = 1;
    step(3);
    chk("R11 hi in reset", hi_en, 0);
    chk("R11 lo in reset", lo_en, 0);
    chk("R11 strobe in reset", oc_s, 0);
    chk("R11 fault in reset", fault, 0);
    rst_n = 1;
    step(2);
    chk("R11 idle after reset", {28'd0, hi_en, lo_en, oc_s, fault}, 0);
  endtask

  task automatic t_basic_ccm();
    ccm = 1; zc = 0;
    pwm = 1;
    step(1); chk("R2 dead cycle", hi_en, 0);
    step(1); chk("R2 upper on", hi_en, 1);
    step(9); pwm = 0;
    step(1); chk("R4 upper off", hi_en, 0); chk("R3 lower dead", lo_en, 0);
    step(1); chk("R3 lower on", lo_en, 1);
    step(OC - 1); chk("R6 strobe early", oc_s, 0);
    step(1); chk("R6 strobe", oc_s, 1);
    step(1); chk("R6 strobe single", oc_s, 0);
    zc = 1;
    step(20); chk("R8 zc ignored", lo_en, 1);
    zc = 0; pwm = 1;
    step(1); chk("R8 lower off on pwm rise", lo_en, 0); chk("R1 both low", hi_en, 0);
    step(1); chk("R2 upper after lower", hi_en, 1);
    go_idle();
  endtask

  task automatic t_min_off();
    ccm = 1; zc = 0;
    pwm = 1; step(2); chk("R2 upper on", hi_en, 1);
    step(4); pwm = 0;
    step(1);
    step(1); chk("R3 lower on", lo_en, 1);
    pwm = 1;
    step(OC - 1); chk("R6 lower held", lo_en, 1); chk("R6 no strobe yet", oc_s, 0);
    step(1); chk("R6 strobe under early pwm", oc_s, 1); chk("R6 lower at strobe", lo_en, 1);
    step(1); chk("R6 lower released", lo_en, 0);
    for (int i = 0; i < MIN_OFF + 10; i++) begin
      if (hi_en) break;
      step(1);
    end
    step(1);
    chk("R5 upper returned", hi_en, 1);
    chk("R5 gap at least min", int'(last_gap >= MIN_OFF), 1);
    chk("R5 gap prompt", int'(last_gap <= MIN_OFF + 1), 1);
    go_idle();
  endtask

  task automatic t_dcm();
    ccm = 0; zc = 0;
    pwm = 1; step(2); chk("R2 upper on", hi_en, 1);
    step(5); zc = 1; pwm = 0;
    step(2); chk("R7 lower on despite early zc", lo_en, 1);
    step(OC); chk("R7 lower held to strobe", lo_en, 1);
    step(1); chk("R7 zc cuts lower", lo_en, 0);
    zc = 0; ccm = 1;
    step(10); chk("R7 latched off", lo_en, 0);
    step(MIN_OFF);
    pwm = 1; step(2); chk("R2 upper on", hi_en, 1);
    step(3); pwm = 0;
    step(2); chk("R7 lower after next fall", lo_en, 1);
    ccm = 0;
    step(OC + 5); zc = 1;
    step(1); chk("R7 late zc cuts lower", lo_en, 0);
    go_idle();
  endtask

  task automatic t_same_cycle();
    ccm = 0; zc = 0;
    pwm = 1; step(2); chk("R2 upper on", hi_en, 1);
    step(3); pwm = 0;
    step(2); chk("R3 lower on", lo_en, 1);
    step(MIN_OFF + 5); chk("R7 lower held without zc", lo_en, 1);
    pwm = 1; zc = 1;
    step(1); chk("R7 lower off on coincidence", lo_en, 0); chk("R1 upper waits", hi_en, 0);
    step(1); chk("R2 upper wins coincidence", hi_en, 1);
    zc = 0; step(3); pwm = 0;
    step(2); chk("R7 lower after fall", lo_en, 1);
    go_idle();
  endtask

  task automatic t_feedback();
    ccm = 1; zc = 0;
    fb_auto = 0; lo_off = 0; hi_off = 1;
    pwm = 1;
    step(10); chk("R2 blocked by lower gate", hi_en, 0);
    lo_off = 1;
    step(1); chk("R2 upper after flag", hi_en, 1);
    hi_off = 0;
    step(3); pwm = 0;
    step(10); chk("R3 blocked by upper gate", lo_en, 0); chk("R4 upper off", hi_en, 0);
    hi_off = 1;
    step(1); chk("R3 lower after flag", lo_en, 1);
    fb_auto = 1;
    go_idle();
  endtask

  task automatic t_hiz();
    logic lo_seen;
    ccm = 1; zc = 0;
    pwm = 1; step(2); chk("R2 upper on", hi_en, 1);
    hiz = 1;
    step(1); chk("R9 hiz upper", hi_en, 0); chk("R9 hiz lower", lo_en, 0);
    pwm = 0;
    step(5); chk("R9 hiz over pwm fall", {30'd0, hi_en, lo_en}, 0);
    pwm = 1;
    step(5); chk("R9 hiz over pwm rise", hi_en, 0);
    hiz = 0; lo_seen = 0;
    for (int i = 0; i < MIN_OFF + 20; i++) begin
      if (hi_en) break;
      if (lo_en) lo_seen = 1;
      step(1);
    end
    chk("R9 upper resumes", hi_en, 1);
    chk("R9 lower stayed off", lo_seen, 0);
    pwm = 0;
    step(2); chk("R3 lower on", lo_en, 1);
    hiz = 1;
    step(1); chk("R9 hiz cuts lower", lo_en, 0);
    hiz = 0;
    step(10); chk("R9 lower not resumed", lo_en, 0);
    go_idle();
  endtask

  task automatic t_watchdog();
    fb_auto = 0; lo_off = 0; hi_off = 1;
    pwm = 1;
    step(TO); chk("R10 no fault yet", fault, 0);
    step(1); chk("R10 fault raised", fault, 1);
    chk("R10 both off", {30'd0, hi_en, lo_en}, 0);
    lo_off = 1;
    step(5); chk("R10 fault sticky", fault, 1); chk("R10 upper held off", hi_en, 0);
    pwm = 0;
    step(5); chk("R10 lower held off", lo_en, 0);
    fb_auto = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; overlap_seen = 0; prev_hi = 0;
    low_run = 0; last_gap = 0;
    lo_off = 1; hi_off = 1;
    t_reset();
    t_basic_ccm();
    t_min_off();
    t_dcm();
    t_same_cycle();
    t_feedback();
    t_hiz();
    t_watchdog();
    t_reset();
    chk("R1 no overlap seen", overlap_seen, 0);
    finish_run();
  end

endmodule